// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge and Completion

This block collects interrupts for a single processor and tracks the lifecycle of each one. It arbitrates among the waiting interrupts by a programmable priority and drives one request line to the processor. Peripheral lines can be configured as level or edge sensitive. Software can also raise any of the sixteen low IDs by writing a trigger register. Each ID holds two state bits, waiting and in-service. These give four states: idle, waiting, in-service, and in-service-with-another-waiting. Another assertion that arrives while an ID is already waiting is absorbed, not counted.

Software talks to the block through a simple synchronous register port. A read of the claim register returns the winning ID and puts it in service. A write of that ID to the completion register ends it. In split mode, completion only lowers the running priority, and a later write to a release register leaves the service state. A request is presented only when the winner's priority is strictly better than both a mask threshold and the best priority still in service, so a better interrupt can preempt a worse one.

Top module: `pic_top`

## Requirements
- R1: After synchronous reset, every ID is idle, `irq_req` is low, the mask threshold, mode bit, edge-select bits and all priorities are zero, and `reg_rdata` is zero.
- R2: Peripheral ID 16+k follows `irq_src[k]`. When edge-select bit k (register 6) is 0, each cycle the line is high sets the ID waiting. When the bit is 1, only a low-to-high change does. The waiting flag is one bit, so repeated assertions yield one service.
- R3: Among the IDs that are waiting and not in service, the winner has the numerically lowest 8-bit priority, and ties go to the lower ID.
- R4: `irq_req` is high exactly when a winner exists whose priority is below the mask threshold (register 4, bits 7:0) and below the running priority. The running priority is the lowest priority among claimed IDs not yet completed, and 255 when there are none.
- R5: A read of register 0 loads `reg_rdata` on the next edge. While `irq_req` is high, the read returns the winner's ID and moves it from waiting to in service. Otherwise it returns 1023 and changes no state. Reads of registers 4, 5 and 6 return their contents; other reads return 0.
- R6: An assertion or trigger that arrives for an ID in service makes it in-service-and-waiting. Once that ID leaves service, it is waiting again and can be claimed again.
- R7: A write of an ID to register 1 drops that ID's contribution to the running priority. With the mode bit clear, the same write also takes it out of service. The write is ignored when the ID is not claimed-and-uncompleted, or is 32 or above.
- R8: With the mode bit (register 5, bit 0) set, a completion leaves the ID in service. A write of the ID to register 2 then takes it out of service, but only after its completion. Otherwise, or with the mode bit clear, the write is ignored.
- R9: A write to register 3 with bits 9:4 zero sets ID bits 3:0 waiting. Any other value is ignored.
- R10: A write to register 7 sets the priority of ID bits 9:0 to bits 23:16, and is ignored for IDs of 32 or above. Register 4 holds the mask threshold and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | N_IRQ-16 | Peripheral interrupt lines, bit k for ID 16+k |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest states to reach from the ports are in-service-and-waiting and the split-mode window. In that window an ID has been completed but not released, and it must neither be claimed nor block others by priority. The stimulus gets there by holding a level line high across a claim, and by raising a software trigger again after a split-mode completion. It then shows that a claim returns 1023 until the release write. Preemption is driven by claiming a mid-priority interrupt and then raising a better and a worse one, so that the running-priority comparison decides the request line.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
// Shared constants and register selectors for the interrupt controller.
package pic_pkg;
    localparam int ID_W        = 10;
    localparam int SGI_NUM     = 16;
    localparam int SPURIOUS_ID = 1023;

    typedef enum logic [2:0] {
        RA_CLAIM   = 3'd0,
        RA_DONE    = 3'd1,
        RA_RELEASE = 3'd2,
        RA_SWTRIG  = 3'd3,
        RA_MASK    = 3'd4,
        RA_MODE    = 3'd5,
        RA_EDGESEL = 3'd6,
        RA_PRIO    = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/pic_src_detect.sv
`timescale 1ns/1ps
// Turns peripheral lines into per-cycle "set waiting" requests.
// Assumes lines are already synchronous to clk. Edge-selected bits fire
// on a low-to-high change only; level bits fire every cycle they are high.
module pic_src_detect #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] edge_sel,
    output logic [N_SRC-1:0] set_req
);
    logic [N_SRC-1:0] src_q;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_line
        assign set_req[g] = edge_sel[g] ? (src[g] & ~src_q[g]) : src[g];
    end
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
// Picks the candidate with the numerically lowest priority; the scan runs
// from ID 0 upward with a strict compare, so ties keep the lower ID.
// Purely combinational.
module pic_arbiter #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 8,
    parameter int ID_W   = 10
) (
    input  logic [N_IRQ-1:0]             cand,
    input  logic [N_IRQ-1:0][PRIO_W-1:0] prio,
    output logic                         found,
    output logic [ID_W-1:0]              win_id,
    output logic [PRIO_W-1:0]            win_prio
);
    // Linear scan for the best waiting candidate.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (!found || prio[i] < win_prio)) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_running_prio.sv
`timescale 1ns/1ps
// Computes the running priority: the best priority among claimed IDs that
// have not been completed, or all ones when none are outstanding.
module pic_running_prio #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 8
) (
    input  logic [N_IRQ-1:0]             run,
    input  logic [N_IRQ-1:0][PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0]            run_prio
);
    // Minimum over outstanding claims.
    always_comb begin
        run_prio = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (run[i] && prio[i] < run_prio) run_prio = prio[i];
        end
    end
endmodule

// File: rtl/pic_top.sv
`timescale 1ns/1ps
// Single-processor interrupt controller top. Holds per-ID waiting,
// in-service and claimed-not-completed bits, priorities, the mask threshold
// and the split-completion mode. Assumes at most one register access per
// cycle, 16 < N_IRQ <= 1020 and N_IRQ-16 <= DATA_W.
module pic_top
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IRQ-SGI_NUM-1:0] irq_src,
    input  logic                     reg_we,
    input  logic                     reg_re,
    input  logic [2:0]               reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     irq_req
);
    localparam int N_PER  = N_IRQ - SGI_NUM;
    localparam int PRIO_LSB = 16;

    logic [N_IRQ-1:0]             pend_q, act_q, run_q;
    logic [N_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]            mask_q;
    logic                         split_q;
    logic [N_PER-1:0]             edge_q;
    logic [DATA_W-1:0]            rdata_q;

    logic [N_PER-1:0]  per_set;
    logic              found;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio, run_prio;

    logic [ID_W-1:0]  acc_id;
    logic             id_ok, ack_take, eoi_hit, deact_hit, sgi_ok;
    logic [N_IRQ-1:0] id_hot, win_hot, ack_hot, eoi_hot, deact_hot, sgi_hot, set_all;
    logic             unused_wdata;

    pic_src_detect #(.N_SRC(N_PER)) u_src (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .edge_sel(edge_q), .set_req(per_set)
    );

    pic_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .cand(pend_q & ~act_q), .prio(prio_q),
        .found(found), .win_id(win_id), .win_prio(win_prio)
    );

    pic_running_prio #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_run (
        .run(run_q), .prio(prio_q), .run_prio(run_prio)
    );

    // Request gate: winner must beat both the mask and the running priority.
    assign irq_req = found && (win_prio < mask_q) && (win_prio < run_prio);

    // Access decode into one-hot ID vectors.
    assign acc_id       = reg_wdata[ID_W-1:0];
    assign id_ok        = acc_id < ID_W'(N_IRQ);
    assign id_hot       = id_ok ? (N_IRQ'(1) << acc_id) : '0;
    assign win_hot      = N_IRQ'(1) << win_id;
    assign ack_take     = reg_re && (reg_addr == RA_CLAIM) && irq_req;
    assign eoi_hit      = reg_we && (reg_addr == RA_DONE);
    assign deact_hit    = reg_we && (reg_addr == RA_RELEASE) && split_q;
    assign sgi_ok       = reg_we && (reg_addr == RA_SWTRIG) && (reg_wdata[ID_W-1:4] == '0);
    assign ack_hot      = ack_take ? win_hot : '0;
    assign eoi_hot      = eoi_hit ? (id_hot & run_q) : '0;
    assign deact_hot    = deact_hit ? (id_hot & act_q & ~run_q) : '0;
    assign sgi_hot      = sgi_ok ? (N_IRQ'(1) << reg_wdata[3:0]) : '0;
    assign set_all      = {per_set, {SGI_NUM{1'b0}}} | sgi_hot;
    assign unused_wdata = ^reg_wdata[DATA_W-1:PRIO_LSB+PRIO_W];

    // Lifecycle state: claims, completions, releases and new assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
            run_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_hot) | set_all;
            run_q  <= (run_q | ack_hot) & ~eoi_hot;
            act_q  <= (act_q | ack_hot) & ~(split_q ? deact_hot : eoi_hot);
        end
    end

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            split_q <= 1'b0;
            edge_q  <= '0;
            prio_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_MASK:    mask_q  <= reg_wdata[PRIO_W-1:0];
                RA_MODE:    split_q <= reg_wdata[0];
                RA_EDGESEL: edge_q  <= reg_wdata[N_PER-1:0];
                RA_PRIO: begin
                    for (int i = 0; i < N_IRQ; i++)
                        if (id_hot[i]) prio_q[i] <= reg_wdata[PRIO_LSB +: PRIO_W];
                end
                default: ;
            endcase
        end
    end

    // Registered read data, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (reg_re) begin
            case (reg_addr)
                RA_CLAIM:   rdata_q <= irq_req ? DATA_W'(win_id) : DATA_W'(SPURIOUS_ID);
                RA_MASK:    rdata_q <= DATA_W'(mask_q);
                RA_MODE:    rdata_q <= DATA_W'(split_q);
                RA_EDGESEL: rdata_q <= DATA_W'(edge_q);
                default:    rdata_q <= '0;
            endcase
        end
    end
    assign reg_rdata = rdata_q;

    // A granted claim reports the winner and leaves it in service.
    p_claim_to_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (reg_rdata[ID_W-1:0] == $past(win_id)) && ((act_q & $past(win_hot)) != '0));

    // An empty claim reports 1023 and touches no service state.
    p_empty_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == RA_CLAIM && !irq_req && !reg_we)
        |=> (reg_rdata == DATA_W'(SPURIOUS_ID)) && $stable(act_q) && $stable(run_q));

    // A claimed-not-completed ID is always in service.
    p_run_in_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q & ~act_q) == '0);

    // The request line needs a waiting ID that is not in service.
    p_req_has_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pend_q & ~act_q) != '0));

    // Completion of an outstanding claim clears it.
    p_done_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && ((id_hot & run_q) != '0)) |=> ((run_q & $past(id_hot)) == '0));

    // Completion naming a non-outstanding ID changes nothing.
    p_done_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && ((id_hot & run_q) == '0) && !reg_re) |=> $stable(run_q) && $stable(act_q));
endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
// Bench for pic_top: behavioural reference compared every cycle plus
// directed checks with hand-computed expectations.
module tb_pic_top;
    localparam int NI = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, re = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [15:0] src = '0;
    wire  [31:0] rdata;
    wire         irq;

    int total = 0, bad = 0;
    bit done = 0, live = 0;

    // reference state
    int rp[NI], ra[NI], rr[NI], rpr[NI];
    int rpm = 0, rsp = 0, redge = 0, rrd = 0;
    int rsq[16];

    pic_top dut (
        .clk(clk), .rst_n(rst_n), .irq_src(src), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_req(irq)
    );

    always #10 clk = ~clk;

    function automatic int ref_win();
        int w = -1;
        for (int i = 0; i < NI; i++)
            if (rp[i] != 0 && ra[i] == 0 && (w < 0 || rpr[i] < rpr[w])) w = i;
        return w;
    endfunction

    function automatic int ref_run();
        int m = 255;
        for (int i = 0; i < NI; i++)
            if (rr[i] != 0 && rpr[i] < m) m = rpr[i];
        return m;
    endfunction

    function automatic bit ref_req();
        int w = ref_win();
        return (w >= 0) && (rpr[w] < rpm) && (rpr[w] < ref_run());
    endfunction

    // Reference model update at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NI; i++) begin rp[i] = 0; ra[i] = 0; rr[i] = 0; rpr[i] = 0; end
            for (int k = 0; k < 16; k++) rsq[k] = 0;
            rpm = 0; rsp = 0; redge = 0; rrd = 0;
        end else begin
            int w, id, np[NI], na[NI], nr[NI];
            bit rq;
            w  = ref_win();
            rq = ref_req();
            id = int'(wdata[9:0]);
            for (int i = 0; i < NI; i++) begin np[i] = rp[i]; na[i] = ra[i]; nr[i] = rr[i]; end
            if (re && addr == 3'd0 && rq) begin np[w] = 0; na[w] = 1; nr[w] = 1; end
            if (we && addr == 3'd1 && id < NI && rr[id] != 0) begin
                nr[id] = 0;
                if (rsp == 0) na[id] = 0;
            end
            if (we && addr == 3'd2 && rsp != 0 && id < NI && ra[id] != 0 && rr[id] == 0) na[id] = 0;
            if (we && addr == 3'd3 && id < 16) np[id] = 1;
            for (int k = 0; k < 16; k++) begin
                bit lvl, rise;
                lvl  = src[k];
                rise = src[k] && rsq[k] == 0;
                if (((redge >> k) & 1) != 0 ? rise : lvl) np[16+k] = 1;
            end
            if (re) begin
                case (addr)
                    3'd0: rrd = rq ? w : 1023;
                    3'd4: rrd = rpm;
                    3'd5: rrd = rsp;
                    3'd6: rrd = redge;
                    default: rrd = 0;
                endcase
            end
            if (we) begin
                case (addr)
                    3'd4: rpm = int'(wdata[7:0]);
                    3'd5: rsp = int'(wdata[0]);
                    3'd6: redge = int'(wdata[15:0]);
                    3'd7: if (id < NI) rpr[id] = int'(wdata[23:16]);
                    default: ;
                endcase
            end
            for (int i = 0; i < NI; i++) begin rp[i] = np[i]; ra[i] = na[i]; rr[i] = nr[i]; end
            for (int k = 0; k < 16; k++) rsq[k] = src[k] ? 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if (live && !done) begin
            chk(irq == ref_req(), "R4 request line vs model", int'(irq), int'(ref_req()));
            chk(rdata == 32'(rrd), "R5 read data vs model", int'(rdata), rrd);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); we = 1'b1; addr = 3'(a); wdata = 32'(d);
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); re = 1'b1; addr = 3'(a);
        @(negedge clk); re = 1'b0; v = int'(rdata);
    endtask

    task automatic pulse(input int k);
        @(negedge clk); src[k] = 1'b1;
        @(negedge clk); src[k] = 1'b0;
    endtask

    task automatic claim_is(input int exp, input string tag);
        int v;
        rd(0, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic req_is(input bit exp, input string tag);
        chk(irq == exp, tag, int'(irq), int'(exp));
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        // R1 reset state
        req_is(0, "R1 request low after reset");
        chk(rdata == 0, "R1 read data zero after reset", int'(rdata), 0);
        rd(4, v); chk(v == 0, "R1 mask zero after reset", v, 0);
        wr(3, 5);
        req_is(0, "R1 zero mask blocks priority 0");
        wr(4, 255);
        // R9 software trigger
        req_is(1, "R9 trigger raises request");
        claim_is(5, "R9 claim returns triggered ID");
        req_is(0, "R4 nothing beats running priority 0");
        wr(1, 5);
        claim_is(1023, "R7 completion leaves nothing waiting");
        // R3 arbitration with ties
        wr(7, (8'h30 << 16) | 20);
        wr(7, (8'h30 << 16) | 18);
        wr(7, (8'h40 << 16) | 3);
        @(negedge clk); src[2] = 1'b1; src[4] = 1'b1;
        wr(3, 3);
        @(negedge clk); src[2] = 1'b0; src[4] = 1'b0;
        claim_is(18, "R3 tie goes to lower ID");
        req_is(0, "R4 equal priority does not preempt");
        wr(1, 18);
        req_is(1, "R4 request after completion");
        claim_is(20, "R3 next best after tie");
        wr(1, 20);
        claim_is(3, "R3 worse priority served last");
        wr(1, 3);
        // R6 level line held across a claim
        @(negedge clk); src[9] = 1'b1;
        claim_is(25, "R2 level line claimed");
        @(negedge clk); src[9] = 1'b0;
        wr(1, 25);
        req_is(1, "R6 waiting again after completion");
        claim_is(25, "R6 reclaimed after active-and-waiting");
        wr(1, 25);
        claim_is(1023, "R6 single pending only");
        // R2 edge mode: long pulse gives one service
        wr(6, 1 << 10);
        rd(6, v); chk(v == (1 << 10), "R2 edge select reads back", v, 1 << 10);
        @(negedge clk); src[10] = 1'b1;
        repeat (4) @(negedge clk);
        src[10] = 1'b0;
        claim_is(26, "R2 edge line claimed");
        wr(1, 26);
        claim_is(1023, "R2 held edge line counted once");
        // R4 preemption and masking
        wr(7, (8'h40 << 16) | 21);
        wr(7, (8'h20 << 16) | 22);
        wr(7, (8'h50 << 16) | 23);
        pulse(5);
        claim_is(21, "R4 mid priority claimed");
        pulse(7);
        req_is(0, "R4 worse priority held off");
        pulse(6);
        req_is(1, "R4 better priority preempts");
        claim_is(22, "R4 preempting ID claimed");
        wr(1, 22);
        req_is(0, "R4 still blocked by outer claim");
        wr(1, 21);
        claim_is(23, "R4 worse ID after outer completion");
        wr(1, 23);
        wr(4, 8'h50);
        pulse(7);
        req_is(0, "R4 priority equal to mask blocked");
        claim_is(1023, "R5 empty claim under mask");
        wr(4, 8'h51);
        req_is(1, "R4 mask raised opens request");
        claim_is(23, "R4 claim after mask raise");
        wr(1, 23);
        wr(4, 255);
        // R8 split completion
        wr(5, 1);
        wr(3, 7);
        claim_is(7, "R8 split claim");
        wr(1, 7);
        wr(3, 7);
        claim_is(1023, "R8 completed but unreleased not claimable");
        wr(2, 7);
        req_is(1, "R8 release returns to waiting");
        claim_is(7, "R8 reclaim after release");
        wr(1, 7);
        wr(2, 7);
        claim_is(1023, "R8 fully released");
        wr(3, 8);
        claim_is(8, "R8 claim for early release");
        wr(2, 8);
        wr(1, 8);
        wr(3, 8);
        claim_is(1023, "R8 release before completion ignored");
        wr(2, 8);
        claim_is(8, "R8 later release honoured");
        wr(1, 8);
        wr(2, 8);
        wr(5, 0);
        // R7 completion of a non-claimed ID
        wr(3, 11);
        claim_is(11, "R7 claim");
        wr(1, 12);
        wr(3, 10);
        req_is(0, "R7 wrong ID completion ignored");
        wr(1, 11);
        req_is(1, "R7 right ID completion");
        claim_is(10, "R7 waiting ID claimed");
        wr(1, 10);
        // R10 priority write out of range, R9 bad trigger
        wr(4, 8'h80);
        wr(7, (8'h90 << 16) | 60);
        pulse(12);
        req_is(1, "R10 out-of-range priority write ignored");
        claim_is(28, "R10 claim with unchanged priority");
        wr(1, 28);
        wr(3, 32'h13);
        claim_is(1023, "R9 trigger with high bits ignored");
        rd(4, v); chk(v == 8'h80, "R10 mask readback", v, 8'h80);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule